// File: doc/BRIEF.md
# Serial Flash Clock and Select Framer

This block produces the serial clock and the four active-low device-select lines for a quad-lane serial flash controller. It runs from a reference clock, and every delay and clock half-period is counted in reference clocks. The data shifters and the command sequencer sit outside this block. From here they receive only the clock edges, a strobe that marks each sampling edge, a strobe that marks each launching edge, and a completion pulse.

Each transfer runs the same frame. A device-switch gap comes first, and only when the target select differs from the previous transfer. The select then goes low, a set-up gap passes, and the clock toggles twice for each requested bit. After a hold gap the select goes high, and a deselect gap must pass before a one-cycle done pulse appears. The divisor, the clock mode, the select field with its decode option and the four gap lengths are captured into held copies only while the enable input is low. Software changes them by dropping the enable, writing the new values and raising the enable again.

Top module: `sflash_frame_gen`

## Requirements
- R1: One clock half-period lasts div+1 reference clocks, so consecutive serial clock edges are div+1 cycles apart (div from 0 to 15).
- R2: Outside a frame the serial clock rests at the held polarity bit, and it returns to that level after the last edge of a frame.
- R3: When the phase bit is 0, the odd-numbered edges (1st, 3rd, ...) carry the sample strobe and the even-numbered edges carry the launch strobe. When the phase bit is 1 the roles are swapped. Each strobe is high in the same cycle that the clock shows its new level.
- R4: With decode off, the low two bits of the select field name a device, and the lines go low one-hot: device 0 gives 1110, 1 gives 1101, 2 gives 1011, 3 gives 0111.
- R5: With decode on, the 4-bit select field is driven unchanged onto the lines during a frame.
- R6: The first clock edge comes exactly the set-up gap in cycles after the select goes low.
- R7: The select goes high exactly the hold gap in cycles after the last clock edge.
- R8: The done pulse comes exactly the deselect gap in cycles after the select goes high. A request held high through the done cycle starts the next frame one cycle later, so the select stays high for the deselect gap plus one cycle.
- R9: When the select pattern differs from that of the previous frame, the select goes low a switch gap of cycles after the request is accepted. Otherwise it goes low in the accepting cycle itself, and the first frame after reset never waits.
- R10: A programmed gap of 0 behaves as 1 cycle, so the select never moves in the same cycle as the clock.
- R11: Done is high for exactly one cycle per frame. Idle is high only when no frame is in progress, and while idle all select lines are high.
- R12: A request while the enable is low is ignored. Setting changes made while the enable is high have no effect on the frames that follow.
- R13: A frame of N bits yields exactly 2N clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Controller enable; low allows settings to load |
| cfg_div | input | 4 | Clock divisor, half-period = div+1 |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_cpha | input | 1 | Clock phase (swaps sample/launch edges) |
| cfg_cs | input | 4 | Select field: device number or raw pattern |
| cfg_dec | input | 1 | 1 = drive select field unchanged |
| cfg_t_setup | input | 8 | Select-low to first edge gap |
| cfg_t_hold | input | 8 | Last edge to select-high gap |
| cfg_t_desel | input | 8 | Minimum select-high gap after a frame |
| cfg_t_switch | input | 8 | Extra gap before selecting a different device |
| xfer_req | input | 1 | Frame request, accepted while idle and enabled |
| xfer_bits | input | 6 | Number of bit cycles in the frame |
| sclk | output | 1 | Serial clock |
| cs_n | output | 4 | Active-low select lines |
| samp_stb | output | 1 | Marks a sampling clock edge |
| shift_stb | output | 1 | Marks a launching clock edge |
| done | output | 1 | One-cycle end-of-frame pulse |
| idle | output | 1 | No frame in progress |

## Verification
The done pulse of one frame and the acceptance of the next request can fall in the same cycle, and the held settings can be reloaded in that same idle window. The bench holds the request high across a whole frame so that the sequencer meets it again in the done cycle. It then checks that exactly one done pulse was seen, that the second select goes low in the cycle right after it, and that the select-high time equals the deselect gap plus one. A second case toggles the settings while the enable is high and checks that the next frame still uses the old divisor and device.

// File: rtl/sff_pkg.sv
// Shared types for the serial flash framer.
// Assumes: one state encoding used by the sequencer and the top level.
package sff_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SWITCH,
        ST_SETUP,
        ST_CLK,
        ST_HOLD,
        ST_DESEL
    } sff_state_e;
endpackage

// File: rtl/sff_cfg_hold.sv
// Held copies of the framer settings and the select pattern built from them.
// Assumes: load is high only while the controller is disabled and idle, so
// settings never change inside a frame.
module sff_cfg_hold #(
    parameter int DIV_W    = 4,
    parameter int DLY_W    = 8,
    parameter int CS_LINES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [DIV_W-1:0]    cfg_div,
    input  logic                cfg_cpol,
    input  logic                cfg_cpha,
    input  logic [CS_LINES-1:0] cfg_cs,
    input  logic                cfg_dec,
    input  logic [DLY_W-1:0]    cfg_t_setup,
    input  logic [DLY_W-1:0]    cfg_t_hold,
    input  logic [DLY_W-1:0]    cfg_t_desel,
    input  logic [DLY_W-1:0]    cfg_t_switch,
    output logic [DIV_W-1:0]    div_q,
    output logic                cpol_q,
    output logic                cpha_q,
    output logic                dec_q,
    output logic [DLY_W-1:0]    su_q,
    output logic [DLY_W-1:0]    hd_q,
    output logic [DLY_W-1:0]    ds_q,
    output logic [DLY_W-1:0]    sw_q,
    output logic [CS_LINES-1:0] cs_pat
);
    localparam int CS_IDX_W = $clog2(CS_LINES);

    logic [CS_LINES-1:0] cs_q;
    logic [CS_IDX_W-1:0] idx;

    // Capture all settings while loading is allowed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            cpol_q <= 1'b0;
            cpha_q <= 1'b0;
            dec_q  <= 1'b0;
            cs_q   <= '0;
            su_q   <= '0;
            hd_q   <= '0;
            ds_q   <= '0;
            sw_q   <= '0;
        end else if (load) begin
            div_q  <= cfg_div;
            cpol_q <= cfg_cpol;
            cpha_q <= cfg_cpha;
            dec_q  <= cfg_dec;
            cs_q   <= cfg_cs;
            su_q   <= cfg_t_setup;
            hd_q   <= cfg_t_hold;
            ds_q   <= cfg_t_desel;
            sw_q   <= cfg_t_switch;
        end
    end

    assign idx = cs_q[CS_IDX_W-1:0];

    // One line per select: raw bit when decoded, one-hot low otherwise.
    for (genvar i = 0; i < CS_LINES; i++) begin : g_line
        assign cs_pat[i] = dec_q ? cs_q[i] : (idx != CS_IDX_W'(i));
    end
endmodule

// File: rtl/sff_seq.sv
// Frame sequencer: switch gap, set-up, clocking, hold and deselect phases.
// Assumes: settings are stable while not idle; a gap of 0 counts as 1 cycle.
// Produces a one-cycle toggle request for every serial clock edge.
module sff_seq
    import sff_pkg::*;
#(
    parameter int DIV_W    = 4,
    parameter int DLY_W    = 8,
    parameter int LEN_W    = 6,
    parameter int CS_LINES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                req,
    input  logic [LEN_W-1:0]    bits,
    input  logic [DIV_W-1:0]    div,
    input  logic [DLY_W-1:0]    su,
    input  logic [DLY_W-1:0]    hd,
    input  logic [DLY_W-1:0]    ds,
    input  logic [DLY_W-1:0]    sw,
    input  logic [CS_LINES-1:0] cs_pat,
    output sff_state_e          st,
    output logic                tog,
    output logic                sel_active,
    output logic                done
);
    localparam int CNT_W = (DLY_W > DIV_W) ? DLY_W : DIV_W;

    logic [CNT_W-1:0]    cnt;
    logic [LEN_W:0]      edges;
    logic [CS_LINES-1:0] last_pat;
    logic                last_vld;

    // Cycle count loaded on entry to a gap phase: the gap minus one, floor 0.
    function automatic logic [CNT_W-1:0] gap_ld(input logic [DLY_W-1:0] d);
        return (d == '0) ? '0 : CNT_W'(d - 1'b1);
    endfunction

    // Phase state, down-counter and remaining-edge count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            edges    <= '0;
            last_pat <= '1;
            last_vld <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (en && req) begin
                        edges    <= {bits, 1'b0};
                        last_pat <= cs_pat;
                        last_vld <= 1'b1;
                        if (last_vld && (last_pat != cs_pat)) begin
                            st  <= ST_SWITCH;
                            cnt <= gap_ld(sw);
                        end else begin
                            st  <= ST_SETUP;
                            cnt <= gap_ld(su);
                        end
                    end
                end
                ST_SWITCH: begin
                    if (cnt == '0) begin
                        st  <= ST_SETUP;
                        cnt <= gap_ld(su);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_SETUP: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (edges == '0) begin
                        st  <= ST_HOLD;
                        cnt <= gap_ld(hd);
                    end else begin
                        st    <= ST_CLK;
                        edges <= edges - 1'b1;
                        cnt   <= CNT_W'(div);
                    end
                end
                ST_CLK: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        edges <= edges - 1'b1;
                        if (edges == (LEN_W+1)'(1)) begin
                            st  <= ST_HOLD;
                            cnt <= gap_ld(hd);
                        end else begin
                            cnt <= CNT_W'(div);
                        end
                    end
                end
                ST_HOLD: begin
                    if (cnt == '0) begin
                        st  <= ST_DESEL;
                        cnt <= gap_ld(ds);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_DESEL: begin
                    if (cnt == '0) begin
                        st   <= ST_IDLE;
                        done <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Edge request: end of set-up (first edge) or end of each half-period.
    assign tog = (cnt == '0) &&
                 (((st == ST_SETUP) && (edges != '0)) || (st == ST_CLK));

    // Select is driven low during set-up, clocking and hold.
    assign sel_active = (st == ST_SETUP) || (st == ST_CLK) || (st == ST_HOLD);
endmodule

// File: rtl/sff_sclk_drv.sv
// Serial clock register and edge-role strobes.
// Assumes: tog pulses once per edge; edge numbering restarts at each frame.
module sff_sclk_drv (
    input  logic clk,
    input  logic rst_n,
    input  logic at_idle,
    input  logic tog,
    input  logic cpol,
    input  logic cpha,
    output logic sclk,
    output logic samp_stb,
    output logic shift_stb
);
    logic odd_q;

    // Clock level, odd/even edge tracking and the two strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk      <= 1'b0;
            odd_q     <= 1'b1;
            samp_stb  <= 1'b0;
            shift_stb <= 1'b0;
        end else begin
            samp_stb  <= tog && (odd_q ^ cpha);
            shift_stb <= tog && !(odd_q ^ cpha);
            if (at_idle) begin
                sclk  <= cpol;
                odd_q <= 1'b1;
            end else if (tog) begin
                sclk  <= ~sclk;
                odd_q <= ~odd_q;
            end
        end
    end
endmodule

// File: rtl/sflash_frame_gen.sv
// Serial flash clock and select framer (top level).
// Assumes: settings load only while en is low and no frame is running;
// requests are accepted only while idle and enabled.
module sflash_frame_gen
    import sff_pkg::*;
#(
    parameter int DIV_W    = 4,
    parameter int DLY_W    = 8,
    parameter int LEN_W    = 6,
    parameter int CS_LINES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [DIV_W-1:0]    cfg_div,
    input  logic                cfg_cpol,
    input  logic                cfg_cpha,
    input  logic [CS_LINES-1:0] cfg_cs,
    input  logic                cfg_dec,
    input  logic [DLY_W-1:0]    cfg_t_setup,
    input  logic [DLY_W-1:0]    cfg_t_hold,
    input  logic [DLY_W-1:0]    cfg_t_desel,
    input  logic [DLY_W-1:0]    cfg_t_switch,
    input  logic                xfer_req,
    input  logic [LEN_W-1:0]    xfer_bits,
    output logic                sclk,
    output logic [CS_LINES-1:0] cs_n,
    output logic                samp_stb,
    output logic                shift_stb,
    output logic                done,
    output logic                idle
);
    sff_state_e          st;
    logic [DIV_W-1:0]    div_q;
    logic                cpol_q, cpha_q, hold_dec;
    logic [DLY_W-1:0]    su_q, hd_q, ds_q, sw_q;
    logic [CS_LINES-1:0] cs_pat;
    logic                tog, sel_active;

    assign idle = (st == ST_IDLE);

    sff_cfg_hold #(.DIV_W(DIV_W), .DLY_W(DLY_W), .CS_LINES(CS_LINES)) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(!en && idle),
        .cfg_div(cfg_div), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_cs(cfg_cs), .cfg_dec(cfg_dec),
        .cfg_t_setup(cfg_t_setup), .cfg_t_hold(cfg_t_hold),
        .cfg_t_desel(cfg_t_desel), .cfg_t_switch(cfg_t_switch),
        .div_q(div_q), .cpol_q(cpol_q), .cpha_q(cpha_q), .dec_q(hold_dec),
        .su_q(su_q), .hd_q(hd_q), .ds_q(ds_q), .sw_q(sw_q), .cs_pat(cs_pat)
    );

    sff_seq #(.DIV_W(DIV_W), .DLY_W(DLY_W), .LEN_W(LEN_W), .CS_LINES(CS_LINES)) u_seq (
        .clk(clk), .rst_n(rst_n), .en(en), .req(xfer_req), .bits(xfer_bits),
        .div(div_q), .su(su_q), .hd(hd_q), .ds(ds_q), .sw(sw_q), .cs_pat(cs_pat),
        .st(st), .tog(tog), .sel_active(sel_active), .done(done)
    );

    sff_sclk_drv u_drv (
        .clk(clk), .rst_n(rst_n), .at_idle(idle), .tog(tog),
        .cpol(cpol_q), .cpha(cpha_q),
        .sclk(sclk), .samp_stb(samp_stb), .shift_stb(shift_stb)
    );

    // Select lines: pattern during the framed phases, all high otherwise.
    assign cs_n = sel_active ? cs_pat : '1;
endmodule

// File: rtl/sflash_frame_gen_chk.sv
// Property checker for the serial flash framer, bound to the top level.
module sflash_frame_gen_chk #(
    parameter int CS_LINES = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                en,
    input logic                idle,
    input logic                done,
    input logic                sclk,
    input logic [CS_LINES-1:0] cs_n,
    input logic                samp_stb,
    input logic                shift_stb,
    input logic                hold_dec
);
    p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_dec |-> ($countones(~cs_n) <= 1));

    p_idle_deselect_r11: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (cs_n == '1));

    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_at_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (idle && cs_n == '1));

    p_sel_apart_from_clk_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sclk) |-> $stable(cs_n));

    p_strobe_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_stb || shift_stb) |-> !$stable(sclk));

    p_no_start_disabled_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && idle) |=> idle);
endmodule

bind sflash_frame_gen sflash_frame_gen_chk #(.CS_LINES(CS_LINES)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .idle(idle), .done(done),
    .sclk(sclk), .cs_n(cs_n), .samp_stb(samp_stb), .shift_stb(shift_stb),
    .hold_dec(hold_dec)
);

// File: tb/sflash_frame_gen_bench.sv
module sflash_frame_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [3:0] cfg_div = '0;
    logic       cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_dec = 1'b0;
    logic [3:0] cfg_cs = '0;
    logic [7:0] cfg_t_setup = '0, cfg_t_hold = '0, cfg_t_desel = '0, cfg_t_switch = '0;
    logic       xfer_req = 1'b0;
    logic [5:0] xfer_bits = '0;
    logic       sclk, samp_stb, shift_stb, done, idle;
    logic [3:0] cs_n;

    sflash_frame_gen u_sflash_frame_gen (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_div(cfg_div), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .cfg_cs(cfg_cs), .cfg_dec(cfg_dec),
        .cfg_t_setup(cfg_t_setup), .cfg_t_hold(cfg_t_hold),
        .cfg_t_desel(cfg_t_desel), .cfg_t_switch(cfg_t_switch),
        .xfer_req(xfer_req), .xfer_bits(xfer_bits), .sclk(sclk), .cs_n(cs_n),
        .samp_stb(samp_stb), .shift_stb(shift_stb), .done(done), .idle(idle)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int nchk = 0, nfail = 0;
    int ne, nfall, nrise, ndone, acc;
    int etime [0:63];
    logic esamp [0:63];
    logic eshift [0:63];
    int fall_t [0:3];
    int rise_t [0:3];
    int done_t [0:3];
    logic [3:0] fall_pat [0:3];
    logic p_sclk = 1'b0;
    logic [3:0] p_cs = 4'hF;

    // Event recorder, sampling away from the active edge.
    always @(negedge clk) begin
        if (sclk !== p_sclk && ne < 64) begin
            etime[ne] = cyc; esamp[ne] = samp_stb; eshift[ne] = shift_stb; ne++;
        end
        if (cs_n !== 4'hF && p_cs === 4'hF && nfall < 4) begin
            fall_t[nfall] = cyc; fall_pat[nfall] = cs_n; nfall++;
        end
        if (cs_n === 4'hF && p_cs !== 4'hF && nrise < 4) begin
            rise_t[nrise] = cyc; nrise++;
        end
        if (done === 1'b1 && ndone < 4) begin
            done_t[ndone] = cyc; ndone++;
        end
        p_sclk = sclk;
        p_cs = cs_n;
    end

    task automatic check(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int eff(input int d);
        return (d == 0) ? 1 : d;
    endfunction

    task automatic mon_clear();
        @(negedge clk); #1;
        ne = 0; nfall = 0; nrise = 0; ndone = 0;
    endtask

    task automatic configure(input int div, input bit cpol, input bit cpha,
                             input int cs, input bit dec, input int su,
                             input int hd, input int ds, input int sw);
        @(negedge clk); #1;
        en = 1'b0;
        cfg_div = 4'(div); cfg_cpol = cpol; cfg_cpha = cpha;
        cfg_cs = 4'(cs); cfg_dec = dec;
        cfg_t_setup = 8'(su); cfg_t_hold = 8'(hd);
        cfg_t_desel = 8'(ds); cfg_t_switch = 8'(sw);
        repeat (2) @(negedge clk);
        #1 en = 1'b1;
        mon_clear();
    endtask

    task automatic start(input int n);
        @(negedge clk); #1;
        xfer_bits = 6'(n);
        xfer_req = 1'b1;
        acc = cyc + 1;
        @(negedge clk); #1;
        xfer_req = 1'b0;
    endtask

    task automatic wait_done(input int k);
        while (ndone < k) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Checks common to every single frame.
    task automatic frame_checks(input int div, input bit cpha, input int cs,
                                input bit dec, input int su, input int hd,
                                input int ds, input int n);
        int ns;
        ns = 0;
        check("R4/R5 select pattern", int'(fall_pat[0]),
              dec ? cs : int'(~(4'b1 << cs[1:0]) & 4'hF));
        check("R13 edge count", ne, 2 * n);
        check("R6/R10 setup gap", etime[0] - fall_t[0], eff(su));
        check("R1 half period", etime[1] - etime[0], div + 1);
        check("R1 last half period", etime[ne-1] - etime[ne-2], div + 1);
        check("R7/R10 hold gap", rise_t[0] - etime[ne-1], eff(hd));
        check("R8/R10 deselect gap", done_t[0] - rise_t[0], eff(ds));
        check("R3 first edge role", int'(esamp[0]), cpha ? 0 : 1);
        check("R3 second edge role", int'(eshift[1]), cpha ? 0 : 1);
        for (int i = 0; i < ne; i++) if (esamp[i]) ns++;
        check("R3 sample strobe count", ns, n);
        check("R11 one done pulse", ndone, 1);
        check("R11 idle after frame", int'(idle), 1);
    endtask

    task automatic t_reset();
        check("R11 reset select high", int'(cs_n), 15);
        check("R11 reset idle", int'(idle), 1);
        check("R11 reset done low", int'(done), 0);
        check("R2 reset clock level", int'(sclk), 0);
    endtask

    task automatic t_mode0();
        configure(0, 0, 0, 2, 0, 3, 2, 4, 0);
        start(4);
        wait_done(1);
        check("R9 first frame no switch gap", fall_t[0] - acc, 0);
        frame_checks(0, 0, 2, 0, 3, 2, 4, 4);
    endtask

    task automatic t_mode3();
        configure(3, 1, 1, 0, 0, 1, 5, 1, 0);
        check("R2 idle level follows polarity", int'(sclk), 1);
        start(3);
        wait_done(1);
        frame_checks(3, 1, 0, 0, 1, 5, 1, 3);
        check("R2 clock back at polarity", int'(sclk), 1);
    endtask

    task automatic t_zero_gaps();
        configure(1, 0, 0, 4'b1010, 1, 0, 0, 0, 0);
        start(2);
        wait_done(1);
        frame_checks(1, 0, 4'b1010, 1, 0, 0, 0, 2);
    endtask

    task automatic t_switch();
        configure(0, 0, 0, 1, 0, 2, 1, 1, 6);
        start(1);
        wait_done(1);
        check("R9 different select waits switch gap", fall_t[0] - acc, 6);
        check("R4 device 1 pattern", int'(fall_pat[0]), 4'b1101);
        mon_clear();
        start(1);
        wait_done(1);
        check("R9 same select no switch gap", fall_t[0] - acc, 0);
    endtask

    task automatic t_back_to_back();
        configure(0, 0, 0, 1, 0, 1, 1, 5, 3);
        @(negedge clk); #1;
        xfer_bits = 6'd2;
        xfer_req = 1'b1;
        while (nfall < 2) @(negedge clk);
        #1 xfer_req = 1'b0;
        wait_done(2);
        check("R8 next select one cycle after done", fall_t[1] - done_t[0], 1);
        check("R8 select high width", fall_t[1] - rise_t[0], 6);
        check("R11 one done per frame", ndone, 2);
    endtask

    task automatic t_disabled();
        configure(0, 0, 0, 3, 0, 1, 1, 1, 0);
        @(negedge clk); #1;
        en = 1'b0;
        xfer_bits = 6'd3;
        xfer_req = 1'b1;
        repeat (2) @(negedge clk);
        #1 xfer_req = 1'b0;
        repeat (8) @(negedge clk);
        check("R12 disabled request no select", nfall, 0);
        check("R12 disabled request no done", ndone, 0);
        check("R12 disabled request stays idle", int'(idle), 1);
    endtask

    task automatic t_locked_settings();
        configure(0, 0, 0, 3, 0, 1, 1, 1, 0);
        @(negedge clk); #1;
        cfg_cs = 4'd0;
        cfg_div = 4'd5;
        start(2);
        wait_done(1);
        check("R12 select unchanged while enabled", int'(fall_pat[0]), 4'b0111);
        check("R12 divisor unchanged while enabled", etime[1] - etime[0], 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++; nchk++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        ne = 0; nfall = 0; nrise = 0; ndone = 0; acc = 0;
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mode0();
        t_mode3();
        t_zero_gaps();
        t_switch();
        t_back_to_back();
        t_disabled();
        t_locked_settings();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule